// File: doc/BRIEF.md
# Sub-word Element Location Sequencer

This block walks a virtual vector that is stored as narrow elements packed side by side in consecutive physical registers. A register can carry an implicit element width narrower than the register itself. In that case each register holds several lanes, and the vector continues into the next register once the lanes of the current one are used up. On a start pulse the block captures a base register number, a 3-bit width code, a vector length counted in registers and an optional element-count override. It then emits one element location per cycle.

Each emitted location carries three things: the element index, the physical register that holds the element, and the lowest and highest bit positions of the element inside that register. These outputs can drive the lane-select multiplexer behind a register read port. When the transfer ends, a single-cycle done pulse follows the last element. A width code that is reserved, or that names an element wider than the register, produces a single-cycle error pulse instead, and no element is emitted.

Top module: `swl_seq`

## Requirements
- R1: After reset, elem_valid, done and cfg_err are all low.
- R2: The width code gives the element width ew. Code 0 means ew = XLEN. Codes 1, 2, 3, 4 and 5 mean ew = 8, 16, 32, 64 and 128 bits. For every emitted element, hi_bit - lo_bit + 1 equals ew.
- R3: Without an override, the number of elements is cfg_vl × (XLEN / ew). They are emitted on consecutive cycles, starting the cycle after start is sampled, with elem_idx running 0, 1, 2 and so on.
- R4: The element with index i sits in register (base_reg + floor(i / (XLEN/ew))) modulo 2^REG_W.
- R5: For the element with index i, lo_bit = (i mod (XLEN/ew)) × ew, and hi_bit = lo_bit + ew - 1.
- R6: When len_ovr_en is high at start, the number of elements emitted is the smaller of len_ovr and the computed count. Elements at the top of the range are skipped.
- R7: done is high for exactly one cycle, the cycle after the last element, and never together with elem_valid. If the element count is zero, done rises the cycle after start and no element is emitted.
- R8: Width codes 6 and 7, and any code with ew > XLEN, raise cfg_err for one cycle after start. No element is emitted and done stays low.
- R9: While a sequence runs, start is ignored and changes on the configuration inputs have no effect. The running sequence keeps the configuration that was captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence; sampled only while idle |
| base_reg | input | REG_W | First physical register of the vector |
| width_code | input | 3 | Element width code |
| cfg_vl | input | VL_W | Vector length in registers |
| len_ovr_en | input | 1 | Enable the element-count override |
| len_ovr | input | EC_W | Element-count override |
| elem_valid | output | 1 | An element location is presented this cycle |
| elem_idx | output | EC_W | Logical element index |
| phys_reg | output | REG_W | Physical register holding the element |
| lo_bit | output | BIT_W | Lowest bit of the element |
| hi_bit | output | BIT_W | Highest bit of the element |
| done | output | 1 | Pulse after the last element |
| cfg_err | output | 1 | Pulse on an illegal width code |

## Verification
The hardest case to reach is a start pulse, or a change to the configuration inputs, arriving in the middle of a running sequence. A sweep that only ever drives clean, isolated starts never exercises it. To reach it, the bench deliberately rewrites the base register, the width code and the vector length during every multi-element run, and also pulses start. It then requires that every remaining element still matches the arithmetic of the configuration captured at the start. The sweep crosses all eight width codes with several register counts, a base near the top of the register space (so the register number wraps) and override values below, equal to and above the computed count.

// File: rtl/swl_pkg.sv
package swl_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_mode_e;

    // base-2 logarithm of a small power-of-two quantity
    typedef logic [2:0] lg_t;
endpackage

// File: rtl/swl_width_dec.sv
module swl_width_dec
    import swl_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [2:0] width_code,
    output lg_t        eb_lg,
    output lg_t        lane_lg,
    output logic       bad
);
    localparam int REG_BYTES_LG = $clog2(XLEN / 8);

    always_comb begin
        bad   = 1'b0;
        eb_lg = lg_t'(REG_BYTES_LG);
        if (width_code == 3'd0) begin
            eb_lg = lg_t'(REG_BYTES_LG);
        end else if (width_code <= 3'd5) begin
            eb_lg = lg_t'(width_code - 3'd1);
        end else begin
            bad   = 1'b1;
            eb_lg = '0;
        end
        if (!bad && (int'(eb_lg) > REG_BYTES_LG)) begin
            bad = 1'b1;
        end
        lane_lg = bad ? '0 : lg_t'(REG_BYTES_LG - int'(eb_lg));
    end
endmodule

// File: rtl/swl_elem_map.sv
module swl_elem_map
    import swl_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int EC_W  = 6
) (
    input  logic [REG_W-1:0]         base_reg,
    input  logic [EC_W-1:0]          idx,
    input  lg_t                      eb_lg,
    input  lg_t                      lane_lg,
    output logic [REG_W-1:0]         phys_reg,
    output logic [$clog2(XLEN)-1:0]  lo_bit,
    output logic [$clog2(XLEN)-1:0]  hi_bit
);
    localparam int BIT_W = $clog2(XLEN);

    logic [EC_W-1:0]       step;
    logic [EC_W-1:0]       lane_mask;
    logic [EC_W-1:0]       lane;
    logic [EC_W+REG_W-1:0] reg_sum;
    logic [3:0]            bit_lg;
    logic [31:0]           ew_bits;
    logic [31:0]           lo_wide;

    always_comb begin
        step      = idx >> lane_lg;
        lane_mask = (EC_W'(1) << lane_lg) - EC_W'(1);
        lane      = idx & lane_mask;
        reg_sum   = {{EC_W{1'b0}}, base_reg} + {{REG_W{1'b0}}, step};
        phys_reg  = reg_sum[REG_W-1:0];
        bit_lg    = {1'b0, eb_lg} + 4'd3;
        ew_bits   = 32'd1 << bit_lg;
        lo_wide   = 32'(lane) << bit_lg;
        lo_bit    = lo_wide[BIT_W-1:0];
        hi_bit    = lo_bit + BIT_W'(ew_bits - 32'd1);
    end
endmodule

// File: rtl/swl_seq.sv
module swl_seq
    import swl_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int VL_W  = 4,
    localparam int LANE_LG_MAX = $clog2(XLEN / 8),
    localparam int EC_W  = VL_W + LANE_LG_MAX,
    localparam int BIT_W = $clog2(XLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] base_reg,
    input  logic [2:0]       width_code,
    input  logic [VL_W-1:0]  cfg_vl,
    input  logic             len_ovr_en,
    input  logic [EC_W-1:0]  len_ovr,
    output logic             elem_valid,
    output logic [EC_W-1:0]  elem_idx,
    output logic [REG_W-1:0] phys_reg,
    output logic [BIT_W-1:0] lo_bit,
    output logic [BIT_W-1:0] hi_bit,
    output logic             done,
    output logic             cfg_err
);
    typedef struct packed {
        seq_mode_e        mode;
        logic [EC_W-1:0]  idx;
        logic [EC_W-1:0]  last;
        logic [REG_W-1:0] base;
        lg_t              eb_lg;
        lg_t              lane_lg;
        logic             done;
        logic             err;
    } seq_st_t;

    seq_st_t st_d, st_q;

    lg_t             in_eb_lg;
    lg_t             in_lane_lg;
    logic            in_bad;
    logic [EC_W-1:0] total_cnt;
    logic [EC_W-1:0] eff_cnt;

    swl_width_dec #(.XLEN(XLEN)) dec_i (
        .width_code (width_code),
        .eb_lg      (in_eb_lg),
        .lane_lg    (in_lane_lg),
        .bad        (in_bad)
    );

    always_comb begin
        total_cnt = EC_W'(cfg_vl) << in_lane_lg;
        eff_cnt   = (len_ovr_en && (len_ovr < total_cnt)) ? len_ovr : total_cnt;

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        unique case (st_q.mode)
            ST_IDLE: begin
                if (start) begin
                    if (in_bad) begin
                        st_d.err = 1'b1;
                    end else if (eff_cnt == '0) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.mode    = ST_RUN;
                        st_d.idx     = '0;
                        st_d.last    = eff_cnt - EC_W'(1);
                        st_d.base    = base_reg;
                        st_d.eb_lg   = in_eb_lg;
                        st_d.lane_lg = in_lane_lg;
                    end
                end
            end
            ST_RUN: begin
                if (st_q.idx == st_q.last) begin
                    st_d.mode = ST_IDLE;
                    st_d.done = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + EC_W'(1);
                end
            end
            default: st_d.mode = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    swl_elem_map #(.XLEN(XLEN), .REG_W(REG_W), .EC_W(EC_W)) map_i (
        .base_reg (st_q.base),
        .idx      (st_q.idx),
        .eb_lg    (st_q.eb_lg),
        .lane_lg  (st_q.lane_lg),
        .phys_reg (phys_reg),
        .lo_bit   (lo_bit),
        .hi_bit   (hi_bit)
    );

    assign elem_valid = (st_q.mode == ST_RUN);
    assign elem_idx   = st_q.idx;
    assign done       = st_q.done;
    assign cfg_err    = st_q.err;
endmodule

// File: rtl/swl_seq_chk.sv
module swl_seq_chk #(
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int VL_W  = 4,
    localparam int EC_W  = VL_W + $clog2(XLEN / 8),
    localparam int BIT_W = $clog2(XLEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             elem_valid,
    input logic [EC_W-1:0]  elem_idx,
    input logic [REG_W-1:0] phys_reg,
    input logic [BIT_W-1:0] lo_bit,
    input logic [BIT_W-1:0] hi_bit,
    input logic             done,
    input logic             cfg_err
);
    // R3
    idx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(elem_valid) |-> elem_idx == '0);

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && $past(elem_valid)) |-> elem_idx == $past(elem_idx) + EC_W'(1));

    // R4
    reg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && $past(elem_valid)) |->
            (phys_reg == $past(phys_reg)) || (phys_reg == $past(phys_reg) + REG_W'(1)));

    // R5
    bit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> hi_bit >= lo_bit);

    // R7
    done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !elem_valid);

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!elem_valid && !done));
endmodule

bind swl_seq swl_seq_chk #(.XLEN(XLEN), .REG_W(REG_W), .VL_W(VL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .elem_valid (elem_valid),
    .elem_idx   (elem_idx),
    .phys_reg   (phys_reg),
    .lo_bit     (lo_bit),
    .hi_bit     (hi_bit),
    .done       (done),
    .cfg_err    (cfg_err)
);

// File: tb/swl_seq_tb_top.sv
module swl_seq_tb_top;
    localparam int XLEN  = 32;
    localparam int REG_W = 5;
    localparam int VL_W  = 4;
    localparam int EC_W  = VL_W + $clog2(XLEN / 8);
    localparam int BIT_W = $clog2(XLEN);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [REG_W-1:0] base_reg = '0;
    logic [2:0]       width_code = '0;
    logic [VL_W-1:0]  cfg_vl = '0;
    logic             len_ovr_en = 1'b0;
    logic [EC_W-1:0]  len_ovr = '0;
    logic             elem_valid;
    logic [EC_W-1:0]  elem_idx;
    logic [REG_W-1:0] phys_reg;
    logic [BIT_W-1:0] lo_bit;
    logic [BIT_W-1:0] hi_bit;
    logic             done;
    logic             cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    swl_seq #(.XLEN(XLEN), .REG_W(REG_W), .VL_W(VL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_reg(base_reg),
        .width_code(width_code), .cfg_vl(cfg_vl), .len_ovr_en(len_ovr_en),
        .len_ovr(len_ovr), .elem_valid(elem_valid), .elem_idx(elem_idx),
        .phys_reg(phys_reg), .lo_bit(lo_bit), .hi_bit(hi_bit),
        .done(done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic run_case(input int base, input int code, input int vl,
                            input bit ov_en, input int ov);
        int  ew;
        bit  legal;
        int  mult;
        int  total;
        int  n;
        legal = 1'b1;
        ew    = XLEN;
        if (code == 0) ew = XLEN;
        else if (code <= 5) ew = 8 << (code - 1);
        else legal = 1'b0;
        if (ew > XLEN) legal = 1'b0;
        mult  = legal ? XLEN / ew : 1;
        total = vl * mult;
        n     = (ov_en && ov < total) ? ov : total;

        @(negedge clk);
        base_reg   = REG_W'(base);
        width_code = 3'(code);
        cfg_vl     = VL_W'(vl);
        len_ovr_en = ov_en;
        len_ovr    = EC_W'(ov);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!legal) begin
            chk(cfg_err == 1'b1, "R8 err pulse", int'(cfg_err), 1);
            chk(elem_valid == 1'b0 && done == 1'b0, "R8 quiet", int'(elem_valid), 0);
            @(negedge clk);
            chk(cfg_err == 1'b0 && elem_valid == 1'b0, "R8 single", int'(cfg_err), 0);
            return;
        end
        if (n == 0) begin
            chk(done == 1'b1 && elem_valid == 1'b0, "R7 zero-count done", int'(done), 1);
            @(negedge clk);
            chk(done == 1'b0, "R7 done single", int'(done), 0);
            return;
        end
        for (int i = 0; i < n; i++) begin
            chk(elem_valid == 1'b1, "R3 valid", int'(elem_valid), 1);
            chk(int'(elem_idx) == i, "R3 index", int'(elem_idx), i);
            chk(int'(phys_reg) == ((base + i / mult) % (1 << REG_W)), "R4 register",
                int'(phys_reg), (base + i / mult) % (1 << REG_W));
            chk(int'(lo_bit) == (i % mult) * ew, "R5 low bit", int'(lo_bit), (i % mult) * ew);
            chk(int'(hi_bit) - int'(lo_bit) + 1 == ew, "R2 element width",
                int'(hi_bit) - int'(lo_bit) + 1, ew);
            chk(done == 1'b0, "R7 no early done", int'(done), 0);
            // R9: disturb start and configuration while running
            if (i == 0) begin
                start      = 1'b1;
                base_reg   = ~REG_W'(base);
                width_code = 3'd1;
                cfg_vl     = VL_W'(7);
                len_ovr_en = ~ov_en;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(done == 1'b1 && elem_valid == 1'b0, "R6/R7 done after last", int'(done), 1);
        @(negedge clk);
        chk(done == 1'b0 && elem_valid == 1'b0, "R9 no restart", int'(elem_valid), 0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        int vls [4] = '{0, 1, 3, 5};
        int bases [2] = '{0, 30};
        repeat (3) @(negedge clk);
        // R1
        chk(elem_valid == 1'b0 && done == 1'b0 && cfg_err == 1'b0, "R1 reset state",
            int'(elem_valid) + int'(done) + int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(elem_valid == 1'b0 && done == 1'b0 && cfg_err == 1'b0, "R1 idle after reset",
            int'(elem_valid) + int'(done) + int'(cfg_err), 0);
        for (int c = 0; c < 8; c++)
            for (int v = 0; v < 4; v++)
                for (int b = 0; b < 2; b++)
                    for (int m = 0; m < 4; m++) begin
                        // R6: override off, 0, 5 (skips top elements), 63 (above count)
                        if (m == 0) run_case(bases[b], c, vls[v], 1'b0, 0);
                        else if (m == 1) run_case(bases[b], c, vls[v], 1'b1, 0);
                        else if (m == 2) run_case(bases[b], c, vls[v], 1'b1, 5);
                        else run_case(bases[b], c, vls[v], 1'b1, 63);
                    end
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end
endmodule